// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block sits behind a byte-wide I/O bus and presents a two-port window into a configuration register space. The first port (at the base address) selects a register number, and the second port (at base plus one) reads or writes that register. The base address is either 0x2E or 0x4E, chosen by a strap input.

Access is normally closed. The host opens it by writing the unlock key 0x87 to the index port twice in a row, and closes it again with a single write of 0xAA. While access is open, register numbers below 0x30 reach a global bank: the logical-device select register, a read-only chip identifier and fourteen option/pin-mux bytes. Register numbers from 0x30 upward belong to whichever logical device is selected. The block holds each device's enable byte at register 0x30 itself. It forwards every higher register number to the downstream devices over a simple single-cycle register strobe interface.

The bus is a single-cycle strobe bus with no back-pressure. A write takes effect on the clock edge where `io_wr` is high. Read data is combinational in the same cycle as `io_rd`, so there is no valid/ready pair at the edge.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset, access is closed, the index and logical-device registers are 0x00, `glob_cfg` and `dev_en` are all zero, and `bank_rd`/`bank_wr` are low.
- R2: Two consecutive index-port writes of 0x87 open access. An index-port write of any other value between them restarts the sequence. Data-port accesses do not affect the sequence.
- R3: While access is open, an index-port write of 0xAA closes access and leaves the index register unchanged. Any other index-port write stores the value as the register number.
- R4: While access is closed, data-port writes change no register and raise no bank strobe, and every read returns 0xFF.
- R5: The index port is at 0x2E when `base_hi` is 0 and at 0x4E when it is 1, and the data port is one above it. Other addresses are ignored. `io_rdata` is 0xFF whenever no open-access read hits a port.
- R6: While access is open, a read of the index port returns the current register number.
- R7: Register 0x07 is the logical-device number, readable and writable.
- R8: Register 0x20 reads CHIP_ID[15:8] and register 0x21 reads CHIP_ID[7:0]. Writes to either have no effect.
- R9: Registers 0x22 to 0x2F are read/write. Register 0x22+k appears on `glob_cfg[8k+7:8k]`. The other global registers read 0x00 and ignore writes.
- R10: Register 0x30 is the enable byte of the selected device d, exported on `dev_en[8d+7:8d]`. When d is NUM_DEV or higher, it reads 0x00 and writes are dropped.
- R11: With access open, a data-port access with register number 0x31 or above raises `bank_rd` or `bank_wr` for that cycle, with `bank_dev` equal to the logical-device number, `bank_addr` equal to the register number and `bank_wdata` equal to the written byte. A read returns `bank_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_hi | input | 1 | Base address strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| glob_cfg | output | 112 | Option/pin-mux bytes for registers 0x22 to 0x2F |
| dev_en | output | NUM_DEV*8 | Enable byte of each logical device |
| bank_dev | output | 8 | Logical device of a forwarded access |
| bank_addr | output | 8 | Register number of a forwarded access |
| bank_wr | output | 1 | Forwarded write strobe |
| bank_rd | output | 1 | Forwarded read strobe |
| bank_wdata | output | 8 | Forwarded write data |
| bank_rdata | input | 8 | Read data returned by the selected device |

## Verification
The unlock logic is tried with several index-write patterns:
- a clean double key;
- a key pair broken by another value, which must stay closed;
- a broken pair followed by a third key, which must open because the second key starts a new pair;
- a data access between two keys, which must not break the pair.

Register traffic is run at both base addresses, plus a write to the unselected base that must have no effect. A write made while closed is followed by reopening and reading the register back. This separates a dropped write from a merely hidden one. Device selects inside and outside the enable array, and the global range edges 0x21, 0x22, 0x2F, 0x30 and 0x31, separate the local registers from the forwarded window.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam logic [7:0] KEY_OPEN       = 8'h87;
  localparam logic [7:0] KEY_CLOSE      = 8'hAA;
  localparam logic [7:0] REG_LDN        = 8'h07;
  localparam logic [7:0] REG_ID_HI      = 8'h20;
  localparam logic [7:0] REG_ID_LO      = 8'h21;
  localparam logic [7:0] REG_GLB_FIRST  = 8'h22;
  localparam logic [7:0] REG_DEV_EN     = 8'h30;
  localparam logic [7:0] REG_BANK_FIRST = 8'h31;
  localparam int         GLB_COUNT      = int'(REG_DEV_EN) - int'(REG_GLB_FIRST);
  localparam logic [15:0] BASE_LO       = 16'h002E;
  localparam logic [15:0] BASE_HI       = 16'h004E;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;
endpackage

// File: rtl/cfgport_key_fsm.sv
module cfgport_key_fsm
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       unlocked,
  output logic       take_index
);
  key_state_e state;

  assign unlocked   = (state == KS_OPEN);
  assign take_index = unlocked && idx_wr && (wdata != KEY_CLOSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= KS_LOCKED;
    end else if (idx_wr) begin
      unique case (state)
        KS_LOCKED: state <= (wdata == KEY_OPEN) ? KS_HALF : KS_LOCKED;
        KS_HALF:   state <= (wdata == KEY_OPEN) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   state <= (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
        default:   state <= KS_LOCKED;
      endcase
    end
  end

  // R2
  key_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == KS_HALF && idx_wr && wdata != KEY_OPEN) |=> !unlocked);

  // R3
  key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && idx_wr && wdata == KEY_CLOSE) |=> !unlocked);
endmodule

// File: rtl/cfgport_global_regs.sv
module cfgport_global_regs
  import cfgport_pkg::*;
#(
  parameter logic [15:0] CHIP_ID = 16'h7A35
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             idx,
  input  logic [7:0]             wdata,
  output logic [7:0]             ldn,
  output logic [GLB_COUNT*8-1:0] glob_cfg,
  output logic [7:0]             rd_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ldn <= 8'h00;
    else if (wr_en && idx == REG_LDN)  ldn <= wdata;
  end

  for (genvar k = 0; k < GLB_COUNT; k++) begin : g_opt
    logic hit;
    assign hit = wr_en && (idx == REG_GLB_FIRST + 8'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   glob_cfg[k*8 +: 8] <= 8'h00;
      else if (hit) glob_cfg[k*8 +: 8] <= wdata;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (idx == REG_LDN)        rd_val = ldn;
    else if (idx == REG_ID_HI) rd_val = CHIP_ID[15:8];
    else if (idx == REG_ID_LO) rd_val = CHIP_ID[7:0];
    else begin
      for (int k = 0; k < GLB_COUNT; k++)
        if (idx == REG_GLB_FIRST + 8'(k)) rd_val = glob_cfg[k*8 +: 8];
    end
  end

  // R9
  glb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(glob_cfg));

  // R7
  ldn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ldn));
endmodule

// File: rtl/cfgport_dev_enables.sv
module cfgport_dev_enables
  import cfgport_pkg::*;
#(
  parameter int NUM_DEV = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           idx,
  input  logic [7:0]           ldn,
  input  logic [7:0]           wdata,
  output logic [NUM_DEV*8-1:0] dev_en,
  output logic [7:0]           rd_val
);
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit;
    assign hit = wr_en && (idx == REG_DEV_EN) && (int'(ldn) == d);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dev_en[d*8 +: 8] <= 8'h00;
      else if (hit) dev_en[d*8 +: 8] <= wdata;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    for (int d = 0; d < NUM_DEV; d++)
      if (int'(ldn) == d) rd_val = dev_en[d*8 +: 8];
  end

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && idx == REG_DEV_EN) |=> $stable(dev_en));
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          NUM_DEV = 16,
  parameter logic [15:0] CHIP_ID = 16'h7A35
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   base_hi,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic [GLB_COUNT*8-1:0] glob_cfg,
  output logic [NUM_DEV*8-1:0]   dev_en,
  output logic [7:0]             bank_dev,
  output logic [7:0]             bank_addr,
  output logic                   bank_wr,
  output logic                   bank_rd,
  output logic [7:0]             bank_wdata,
  input  logic [7:0]             bank_rdata
);
  logic [ADDR_W-1:0] base_addr;
  logic              hit_idx, hit_dat;
  logic              unlocked, take_index;
  logic [7:0]        idx, ldn, glb_rd, en_rd;
  logic              dat_wr, is_bank;

  assign base_addr = base_hi ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO);
  assign hit_idx   = (io_addr == base_addr);
  assign hit_dat   = (io_addr == base_addr + ADDR_W'(1));
  assign dat_wr    = unlocked && io_wr && hit_dat;
  assign is_bank   = (idx >= REG_BANK_FIRST);

  cfgport_key_fsm u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (io_wr && hit_idx),
    .wdata      (io_wdata),
    .unlocked   (unlocked),
    .take_index (take_index)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx <= 8'h00;
    else if (take_index) idx <= io_wdata;
  end

  cfgport_global_regs #(.CHIP_ID(CHIP_ID)) u_glb (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (dat_wr),
    .idx      (idx),
    .wdata    (io_wdata),
    .ldn      (ldn),
    .glob_cfg (glob_cfg),
    .rd_val   (glb_rd)
  );

  cfgport_dev_enables #(.NUM_DEV(NUM_DEV)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (dat_wr),
    .idx    (idx),
    .ldn    (ldn),
    .wdata  (io_wdata),
    .dev_en (dev_en),
    .rd_val (en_rd)
  );

  assign bank_dev   = ldn;
  assign bank_addr  = idx;
  assign bank_wdata = io_wdata;
  assign bank_wr    = dat_wr && is_bank;
  assign bank_rd    = unlocked && io_rd && hit_dat && is_bank;

  always_comb begin
    io_rdata = 8'hFF;
    if (unlocked && io_rd) begin
      if (hit_idx)                 io_rdata = idx;
      else if (hit_dat) begin
        if (idx < REG_DEV_EN)      io_rdata = glb_rd;
        else if (idx == REG_DEV_EN) io_rdata = en_rd;
        else                       io_rdata = bank_rdata;
      end
    end
  end

  // R4
  locked_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !(bank_wr || bank_rd));

  // R11
  bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr || bank_rd) |-> (bank_addr >= REG_BANK_FIRST));

  // R3
  idx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit_idx && io_wdata == KEY_CLOSE) |=> $stable(idx));
endmodule

// File: tb/cfgport_ctrl_tb.sv
module cfgport_ctrl_tb;
  localparam int NUM_DEV = 16;
  localparam int NGLB    = 14;
  localparam logic [15:0] CID = 16'h7A35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_hi = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h0;
  logic [7:0] io_rdata;
  logic [NGLB*8-1:0] glob_cfg;
  logic [NUM_DEV*8-1:0] dev_en;
  logic [7:0] bank_dev, bank_addr, bank_wdata, bank_rdata;
  logic bank_wr, bank_rd;

  int checks = 0;
  int errors = 0;

  // model state
  int ms = 0;
  int m_idx = 0, m_ldn = 0;
  int m_glb[NGLB];
  int m_en[NUM_DEV];

  always #2 clk = ~clk;

  assign bank_rdata = bank_addr ^ bank_dev ^ 8'h3C;

  cfgport_ctrl #(.ADDR_W(16), .NUM_DEV(NUM_DEV), .CHIP_ID(CID)) u_dut (
    .clk(clk), .rst_n(rst_n), .base_hi(base_hi), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .glob_cfg(glob_cfg), .dev_en(dev_en), .bank_dev(bank_dev),
    .bank_addr(bank_addr), .bank_wr(bank_wr), .bank_rd(bank_rd),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata));

  function automatic int base_of();
    return base_hi ? 'h4E : 'h2E;
  endfunction

  function automatic int model_read(int idx);
    if (idx == 'h07) return m_ldn;
    if (idx == 'h20) return CID[15:8];
    if (idx == 'h21) return CID[7:0];
    if (idx >= 'h22 && idx < 'h30) return m_glb[idx - 'h22];
    if (idx == 'h30) return (m_ldn < NUM_DEV) ? m_en[m_ldn] : 0;
    if (idx > 'h30) return (idx ^ m_ldn ^ 'h3C) & 'hFF;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int hit_i = (io_addr == base_of());
    int hit_d = (io_addr == base_of() + 1);
    int exp_rd = 'hFF;
    int exp_brd = 0, exp_bwr = 0;
    if (ms == 2 && io_rd && hit_i) exp_rd = m_idx;
    else if (ms == 2 && io_rd && hit_d) exp_rd = model_read(m_idx);
    if (ms == 2 && hit_d && m_idx > 'h30) begin
      exp_brd = io_rd;
      exp_bwr = io_wr;
    end
    chk(tag, "io_rdata", io_rdata, exp_rd);
    chk(tag, "bank_rd", bank_rd, exp_brd);
    chk(tag, "bank_wr", bank_wr, exp_bwr);
    if (exp_brd || exp_bwr) begin
      chk(tag, "bank_dev", bank_dev, m_ldn);
      chk(tag, "bank_addr", bank_addr, m_idx);
      chk(tag, "bank_wdata", bank_wdata, io_wdata);
    end
    for (int k = 0; k < NGLB; k++)
      if (glob_cfg[k*8 +: 8] != 8'(m_glb[k])) chk(tag, "glob_cfg", glob_cfg[k*8 +: 8], m_glb[k]);
    for (int d = 0; d < NUM_DEV; d++)
      if (dev_en[d*8 +: 8] != 8'(m_en[d])) chk(tag, "dev_en", dev_en[d*8 +: 8], m_en[d]);
  endtask

  task automatic model_step(int a, bit w, int d);
    int hit_i = (a == base_of());
    int hit_d = (a == base_of() + 1);
    if (w && hit_i) begin
      case (ms)
        0: ms = (d == 'h87) ? 1 : 0;
        1: ms = (d == 'h87) ? 2 : 0;
        default: if (d == 'hAA) ms = 0; else m_idx = d;
      endcase
    end else if (w && hit_d && ms == 2) begin
      if (m_idx == 'h07) m_ldn = d;
      else if (m_idx >= 'h22 && m_idx < 'h30) m_glb[m_idx - 'h22] = d;
      else if (m_idx == 'h30 && m_ldn < NUM_DEV) m_en[m_ldn] = d;
    end
  endtask

  task automatic cyc(int a, bit w, bit r, int d, string tag);
    @(negedge clk);
    io_addr = 16'(a); io_wr = w; io_rd = r; io_wdata = 8'(d);
    #1;
    compare(tag);
    @(posedge clk);
    model_step(a, w, d);
  endtask

  task automatic wi(int v, string tag); cyc(base_of(), 1, 0, v, tag); endtask
  task automatic wd(int v, string tag); cyc(base_of() + 1, 1, 0, v, tag); endtask
  task automatic ri(string tag); cyc(base_of(), 0, 1, 0, tag); endtask
  task automatic rd(string tag); cyc(base_of() + 1, 0, 1, 0, tag); endtask
  task automatic open_cfg(string tag); wi('h87, tag); wi('h87, tag); endtask
  task automatic reg_wr(int r, int v, string tag); wi(r, tag); wd(v, tag); endtask
  task automatic reg_rd(int r, string tag); wi(r, tag); rd(tag); endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NGLB; k++) m_glb[k] = 0;
    for (int d = 0; d < NUM_DEV; d++) m_en[d] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cyc(0, 0, 0, 0, "R1");
    ri("R1"); rd("R1");
    // R4: closed port ignores data writes
    wd('h55, "R4"); rd("R4");
    // R2: broken key pair stays closed, then a fresh pair opens
    wi('h87, "R2"); wi('h12, "R2"); rd("R2");
    wi('h87, "R2"); rd("R2"); wi('h87, "R2"); ri("R2");
    // R6 / R3: index readback and close
    wi('h22, "R6"); ri("R6");
    wi('hAA, "R3"); ri("R3");
    open_cfg("R3"); ri("R3");
    // R2: data access between keys does not break the pair
    wi('hAA, "R2"); wi('h87, "R2"); rd("R2"); wi('h87, "R2"); ri("R2");
    // R9: global range edges
    reg_wr('h22, 'h11, "R9"); reg_wr('h2F, 'hE7, "R9"); reg_wr('h25, 'h5A, "R9");
    reg_rd('h22, "R9"); reg_rd('h2F, "R9"); reg_wr('h10, 'h99, "R9"); reg_rd('h10, "R9");
    // R4: write while closed then reopen to look
    wi('h22, "R4"); wi('hAA, "R4"); wd('h99, "R4"); open_cfg("R4"); rd("R4");
    // R8: chip id read-only
    reg_rd('h20, "R8"); reg_rd('h21, "R8"); reg_wr('h20, 'h00, "R8"); rd("R8");
    reg_wr('h21, 'hFF, "R8"); rd("R8");
    // R7 / R10: device select and enables
    for (int d = 0; d < 18; d += 3) begin
      reg_wr('h07, d, "R7"); reg_rd('h07, "R7");
      reg_wr('h30, 'hA0 + d, "R10"); rd("R10");
    end
    reg_wr('h07, 'h40, "R10"); reg_wr('h30, 'h77, "R10"); rd("R10");
    reg_wr('h07, 'h05, "R10"); reg_rd('h30, "R10");
    // R11: forwarded window
    reg_wr('h31, 'hC3, "R11"); rd("R11"); reg_wr('hF0, 'h0F, "R11"); rd("R11");
    reg_wr('h07, 'h09, "R11"); reg_rd('hE5, "R11"); reg_rd('h31, "R11");
    // R5: other base ignored, then switch base
    cyc('h4E, 1, 0, 'h22, "R5"); cyc('h4F, 1, 0, 'h66, "R5"); cyc('h4F, 0, 1, 0, "R5");
    ri("R5"); cyc('h1234, 0, 1, 0, "R5");
    wi('hAA, "R5");
    @(negedge clk); base_hi = 1'b1;
    wi('h87, "R5"); wi('h87, "R5"); reg_wr('h23, 'h3D, "R5"); reg_rd('h23, "R5");
    cyc('h2E, 0, 1, 0, "R5"); cyc('h2F, 1, 0, 'hEE, "R5"); reg_rd('h23, "R5");
    wi('hAA, "R3"); rd("R3");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule